// File: doc/BRIEF.md
# Masked Program Counter Breakpoint Comparator

This block watches the program counter of an executing core and flags when it lands on one of four programmed breakpoint addresses. Each breakpoint slot holds a halfword-aligned compare address. Slots 1 to 3 also hold an arming flag, and slot 0 is armed permanently. A single shared ignore mask removes chosen address bits from every comparison, so one slot can cover an aligned block of code instead of one instruction.

Configuration arrives through a small debug write port that carries a register index and a 32-bit data word. The surrounding trigger logic supplies one enable per slot. A slot reports a hit only when its enable is high, it is armed, and the masked addresses agree. Hits are registered and appear one clock after a qualified program counter sample. A combined flag is also provided.

Top module: `pc_bkpt_cmp`

## Requirements
- R1: Breakpoint slots 0, 1, 2 and 3 are written at indices 0x08, 0x18, 0x1A and 0x1B. Data bits 31:1 form the compare address, which is matched against `pc[31:1]`. Program counter bit 0 never affects a match.
- R2: For slots 1 to 3, data bit 0 is an arming flag. While that flag is 0 the slot never reports a hit.
- R3: Slot 0 ignores data bit 0 when written and is armed whenever its trigger enable is high, including directly after reset.
- R4: The ignore mask is written at index 0x09. A mask bit of 1 excludes the matching address bit from the comparison, and a mask bit of 0 keeps it in.
- R5: Reset clears the mask to zero, which gives a full compare. It also clears every compare address and arming flag, and drives `hitVec` and `hitAny` to 0.
- R6: Bit n of `hitVec` can be 1 only if `trigEnable[n]` was 1 in the sampled cycle.
- R7: Hits are registered. `hitVec` reflects the program counter presented with `pcValid` high on the preceding clock edge, and it is all zero after an edge where `pcValid` was low.
- R8: `hitAny` is 1 exactly when any bit of `hitVec` is 1.
- R9: A write to any index other than 0x08, 0x09, 0x18, 0x1A or 0x1B changes no slot and does not change the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Debug register write strobe |
| wrIdx | input | 8 | Debug register index |
| wrData | input | 32 | Debug register write data |
| pcValid | input | 1 | Program counter sample is valid |
| pc | input | 32 | Program counter |
| trigEnable | input | 4 | Per-slot enable from the trigger configuration |
| hitVec | output | 4 | Registered per-slot hit flags, bit n = slot n |
| hitAny | output | 1 | Registered OR of the slot hits |

## Verification
The comparator is driven with program counters that hit exactly one slot, that hit several slots at once when a wide mask is set, and that differ from a slot address by a single bit. These cases separate the per-slot comparison from the combined flag and show whether each mask bit has any effect. Further patterns pair a matching address with a disarmed slot, a cleared trigger enable, or a low strobe. Each of these gates must suppress the hit on its own. Slot 0 is probed right after reset and after a write with bit 0 clear, to show that it stays armed. Writes to unmapped indices are followed by probes to confirm that the stored state did not change.

// File: rtl/pcbk_pkg.sv
package pcbk_pkg;
  localparam int BP_COUNT = 4;
  localparam int BP0_IDX  = 8'h08;
  localparam int MASK_IDX = 8'h09;
  localparam int BP1_IDX  = 8'h18;
  localparam int BP2_IDX  = 8'h1A;
  localparam int BP3_IDX  = 8'h1B;

  typedef struct packed {
    logic [BP_COUNT-1:0] bpWr;
    logic                maskWr;
  } wrStrb_t;
endpackage

// File: rtl/pcbk_ctrl.sv
module pcbk_ctrl
  import pcbk_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  output wrStrb_t          strb
);
  always_comb begin
    strb         = '0;
    strb.maskWr  = wrEn && (wrIdx == IDX_W'(MASK_IDX));
    strb.bpWr[0] = wrEn && (wrIdx == IDX_W'(BP0_IDX));
    strb.bpWr[1] = wrEn && (wrIdx == IDX_W'(BP1_IDX));
    strb.bpWr[2] = wrEn && (wrIdx == IDX_W'(BP2_IDX));
    strb.bpWr[3] = wrEn && (wrIdx == IDX_W'(BP3_IDX));
  end
endmodule

// File: rtl/pcbk_dp.sv
module pcbk_dp
  import pcbk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wrStrb_t             strb,
  input  logic [ADDR_W-1:0]   wrData,
  input  logic                pcValid,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [BP_COUNT-1:0] trigEnable,
  output logic [BP_COUNT-1:0] hitVec,
  output logic                hitAny
);
  logic [ADDR_W-1:0]   maskQ;
  logic [ADDR_W-1:1]   bpAddrQ [BP_COUNT];
  logic [BP_COUNT-1:1] validQ;
  logic [BP_COUNT-1:0] armed;
  logic [BP_COUNT-1:0] match;
  logic                unusedBits;

  assign unusedBits = ^{maskQ[0], pc[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskQ  <= '0;
      validQ <= '0;
      for (int i = 0; i < BP_COUNT; i++) bpAddrQ[i] <= '0;
    end else begin
      if (strb.maskWr) maskQ <= wrData;
      for (int i = 0; i < BP_COUNT; i++)
        if (strb.bpWr[i]) bpAddrQ[i] <= wrData[ADDR_W-1:1];
      for (int i = 1; i < BP_COUNT; i++)
        if (strb.bpWr[i]) validQ[i] <= wrData[0];
    end
  end

  for (genvar g = 0; g < BP_COUNT; g++) begin : g_slot
    if (g == 0) begin : g_always
      assign armed[g] = 1'b1;
    end else begin : g_gated
      assign armed[g] = validQ[g];
    end
    assign match[g] = (((bpAddrQ[g] ^ pc[ADDR_W-1:1]) & ~maskQ[ADDR_W-1:1]) == '0)
                      && armed[g] && trigEnable[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitVec <= '0;
      hitAny <= 1'b0;
    end else begin
      hitVec <= pcValid ? match : '0;
      hitAny <= pcValid && (match != '0);
    end
  end
endmodule

// File: rtl/pc_bkpt_cmp.sv
module pc_bkpt_cmp
  import pcbk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [ADDR_W-1:0]   wrData,
  input  logic                pcValid,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [BP_COUNT-1:0] trigEnable,
  output logic [BP_COUNT-1:0] hitVec,
  output logic                hitAny
);
  wrStrb_t strb;

  pcbk_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .wrEn(wrEn), .wrIdx(wrIdx), .strb(strb)
  );

  pcbk_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .pcValid(pcValid), .pc(pc), .trigEnable(trigEnable),
    .hitVec(hitVec), .hitAny(hitAny)
  );
endmodule

// File: rtl/pcbk_chk.sv
module pcbk_chk
  import pcbk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wrEn,
  input logic [IDX_W-1:0]    wrIdx,
  input logic                pcValid,
  input logic [BP_COUNT-1:0] trigEnable,
  input logic [BP_COUNT-1:0] hitVec,
  input logic                hitAny,
  input logic [ADDR_W-1:0]   maskQ,
  input logic [BP_COUNT-1:1] validQ
);
  logic mapped;
  assign mapped = (wrIdx == IDX_W'(BP0_IDX)) || (wrIdx == IDX_W'(MASK_IDX)) ||
                  (wrIdx == IDX_W'(BP1_IDX)) || (wrIdx == IDX_W'(BP2_IDX)) ||
                  (wrIdx == IDX_W'(BP3_IDX));

  a_r2_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hitVec[BP_COUNT-1:1] & ~$past(validQ)) == '0);

  a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (hitVec & ~$past(trigEnable)) == '0);

  a_r7_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !pcValid |=> (hitVec == '0));

  a_r8_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
    hitAny == (hitVec != '0));

  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !mapped) |=> ($stable(maskQ) && $stable(validQ)));
endmodule

bind pc_bkpt_cmp pcbk_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .pcValid(pcValid),
  .trigEnable(trigEnable), .hitVec(hitVec), .hitAny(hitAny),
  .maskQ(u_dp.maskQ), .validQ(u_dp.validQ)
);

// File: tb/pc_bkpt_cmp_bench.sv
module pc_bkpt_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        pcValid = 1'b0;
  logic [31:0] pc = '0;
  logic [3:0]  trigEnable = '0;
  logic [3:0]  hitVec;
  logic        hitAny;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pc_bkpt_cmp u_pc_bkpt_cmp (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .pcValid(pcValid), .pc(pc), .trigEnable(trigEnable),
    .hitVec(hitVec), .hitAny(hitAny)
  );

  // pc, trigger enables, expected hits (mask = 0)
  localparam logic [39:0] VEC [8] = '{
    {32'h0000_1000, 4'hF, 4'b0001},   // R1 slot 0
    {32'h0000_2000, 4'hF, 4'b0010},   // R1 R2 slot 1 armed
    {32'h0000_3000, 4'hF, 4'b0100},   // R1 slot 2
    {32'h0000_4000, 4'hF, 4'b0000},   // R2 slot 3 disarmed
    {32'h0000_2000, 4'hD, 4'b0000},   // R6 enable 1 low
    {32'h0000_1004, 4'hF, 4'b0000},   // R5 single bit differs, full compare
    {32'h0000_1001, 4'hF, 4'b0001},   // R1 pc bit 0 ignored
    {32'h0000_5000, 4'hF, 4'b0000}    // R1 no slot
  };

  task automatic check(input string tag, input logic [3:0] exp);
    total++;
    if (hitVec !== exp || hitAny !== (exp != 0)) begin
      bad++;
      $display("FAIL %s: hitVec=%b hitAny=%b expected hitVec=%b hitAny=%b",
               tag, hitVec, hitAny, exp, exp != 0);
    end
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic probe(input logic [31:0] addr, input logic [3:0] en,
                       input logic strobe, input logic [3:0] exp, input string tag);
    @(negedge clk);
    pc = addr; trigEnable = en; pcValid = strobe;
    @(negedge clk);
    pcValid = 1'b0;
    check(tag, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset outputs", 4'b0000);
    rst_n = 1'b1;
    probe(32'h0, 4'hF, 1'b1, 4'b0001, "R3 R5 slot 0 armed after reset");
    probe(32'h10, 4'hF, 1'b1, 4'b0000, "R5 full compare after reset");

    regWrite(8'h08, 32'h0000_1000);
    regWrite(8'h18, 32'h0000_2001);
    regWrite(8'h1A, 32'h0000_3001);
    regWrite(8'h1B, 32'h0000_4000);
    for (int i = 0; i < 8; i++)
      probe(VEC[i][39:8], VEC[i][7:4], 1'b1, VEC[i][3:0], $sformatf("R1 R2 R6 vector %0d", i));

    probe(32'h0000_1000, 4'hF, 1'b0, 4'b0000, "R7 strobe low");
    regWrite(8'h08, 32'h0000_1000);
    probe(32'h0000_1000, 4'h1, 1'b1, 4'b0001, "R3 bit0 clear write");
    probe(32'h0000_1000, 4'hE, 1'b1, 4'b0000, "R6 enable 0 low");

    regWrite(8'h09, 32'h0000_F000);
    probe(32'h0000_0000, 4'hF, 1'b1, 4'b0111, "R4 R8 mask multi-hit");
    probe(32'h0000_0004, 4'hF, 1'b1, 4'b0000, "R4 unmasked bit still compared");

    regWrite(8'h19, 32'h0000_4001);
    regWrite(8'h0A, 32'h0000_0000);
    regWrite(8'h1C, 32'h0000_0001);
    probe(32'h0000_4000, 4'hF, 1'b1, 4'b0111, "R9 unmapped writes ignored");

    regWrite(8'h1B, 32'h0000_4001);
    probe(32'h0000_4000, 4'hF, 1'b1, 4'b1111, "R2 R8 slot 3 armed");
    regWrite(8'h18, 32'h0000_2000);
    probe(32'h0000_4000, 4'hF, 1'b1, 4'b1101, "R2 slot 1 disarmed");

    regWrite(8'h09, 32'h0000_0000);
    probe(32'h0000_4000, 4'hF, 1'b1, 4'b1000, "R4 mask cleared");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe(32'h0000_4000, 4'hF, 1'b1, 4'b0000, "R5 reset clears slots");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule